// File: doc/BRIEF.md
# Registered Carry-Chain Adder/Counter Cluster

This block is a cluster of ten arithmetic slices joined by a private ripple-carry path. Each slice produces two sum bits, so the cluster forms an adder or counter up to 20 bits wide. Each sum bit comes from a full adder, and its two addends are the outputs of two programmable 4-input lookup functions. Each lookup function is a 16-bit truth table, written through a synchronous configuration port before operation. A slice computes its two bits for both possible incoming carries and picks one pair with the real carry, which halves the depth of each carry hop.

The chain can begin at the bottom slice, giving a 20-bit operation. It can also begin at the sixth slice, giving a 10-bit operation in the upper half. The adder result is available combinationally and is also captured by a register. Several controls shape the operation: add or subtract, count up or down from the register, a clock enable and a synchronous clear. The carry leaving the top slice is an output port.

Top module: `carry_cluster`

## Requirements
- R1: Truth table number 2*i holds the first addend of sum bit i and number 2*i+1 holds the second. Bit i uses the nibble din[4*i+3:4*i] as the table address, and the addend equals bit [nibble] of the stored 16-bit table.
- R2: With start_upper=0, cnt_en=0 and sub=0, {carry_out, sum_o} equals A + B + carry_in over 21 bits, where A and B are the 20-bit addend vectors.
- R3: With sub=1 and cnt_en=0, the second addend is inverted and the effective carry-in is carry_in XOR 1. sum_o is then A - B - carry_in, and carry_out is 1 exactly when no borrow occurs.
- R4: With start_upper=1, bits 19:10 carry the 10-bit result of the upper halves under the R2/R3 rules, with carry_out taken from the top. sum_o[9:0] reads 0, and the lower operands have no effect on the upper bits or on carry_out.
- R5: On a clock edge with ce=1 and sclr=0, q_o takes the value sum_o had before the edge.
- R6: On a clock edge with ce=0, q_o keeps its value whatever sclr and cnt_en are. Clock enable outranks synchronous clear.
- R7: On a clock edge with ce=1 and sclr=1, q_o becomes 0, also while counting.
- R8: With cnt_en=1 and cnt_up=1, the adder computes q_o + 1 over the active width and ignores the lookup tables, sub and carry_in. carry_out is 1 exactly when the active part of q_o is all ones.
- R9: With cnt_en=1 and cnt_up=0, the adder adds all ones to q_o over the active width, giving q_o - 1. carry_out is 1 exactly when the active part of q_o is nonzero.
- R10: After reset, q_o is 0 and every truth table is 0, so in full mode sum_o equals carry_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Truth-table write strobe |
| cfg_idx | input | 6 | Truth-table number (2*bit + addend) |
| cfg_tt | input | 16 | Truth-table contents |
| din | input | 80 | Four lookup inputs per sum bit |
| carry_in | input | 1 | Carry into the first active slice |
| sub | input | 1 | 1 = subtract second addend |
| cnt_en | input | 1 | 1 = count from the register |
| cnt_up | input | 1 | Count direction, 1 = up |
| ce | input | 1 | Register clock enable |
| sclr | input | 1 | Synchronous clear of the register |
| start_upper | input | 1 | 1 = chain begins at slice six |
| sum_o | output | 20 | Combinational sum |
| q_o | output | 20 | Registered sum |
| carry_out | output | 1 | Carry out of the top slice |

## Verification
Two register controls can meet on the same edge: counting and synchronous clear, and synchronous clear with the clock enable low. The bench first loads a known count and then raises sclr together with cnt_en. It does this once with ce low, where the count must survive untouched, and once with ce high, where the register must read zero rather than the incremented value. The carry-select path and the start position are exercised by operands whose lower half would carry into the upper half in full mode, and the result is compared against an independent integer sum.

// File: rtl/carry_cluster_pkg.sv
package carry_cluster_pkg;
   typedef enum logic {
      CHAIN_FULL  = 1'b0,
      CHAIN_UPPER = 1'b1
   } chain_start_e;

   typedef enum logic {
      HOP_RIPPLE = 1'b0,
      HOP_SELECT = 1'b1
   } hop_kind_e;

   function automatic int unsigned ttab_width(input int unsigned n_in);
      return 32'd1 << n_in;
   endfunction
endpackage

// File: rtl/carry_cluster_lutbank.sv
module carry_cluster_lutbank #(
   parameter int W      = 20,
   parameter int LUT_IN = 4,
   parameter int AW     = 6
) (
   input  logic                                           clk,
   input  logic                                           rst,
   input  logic                                           cfg_we,
   input  logic [AW-1:0]                                  cfg_idx,
   input  logic [carry_cluster_pkg::ttab_width(LUT_IN)-1:0] cfg_tt,
   input  logic [W*LUT_IN-1:0]                            din,
   output logic [W-1:0]                                   opa,
   output logic [W-1:0]                                   opb
);
   localparam int TTW  = carry_cluster_pkg::ttab_width(LUT_IN);
   localparam int NLUT = 2 * W;

   logic [NLUT-1:0][TTW-1:0] tt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         tt_q <= '0;
      end else if (cfg_we) begin
         for (int k = 0; k < NLUT; k++) begin
            if (cfg_idx == AW'(k)) tt_q[k] <= cfg_tt;
         end
      end
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic [LUT_IN-1:0] nib;
      assign nib    = din[i*LUT_IN +: LUT_IN];
      assign opa[i] = tt_q[2*i][nib];
      assign opb[i] = tt_q[2*i+1][nib];
   end
endmodule

// File: rtl/carry_cluster_slice.sv
module carry_cluster_slice #(
   parameter int                          BPS  = 2,
   parameter carry_cluster_pkg::hop_kind_e HOP = carry_cluster_pkg::HOP_SELECT
) (
   input  logic [BPS-1:0] a,
   input  logic [BPS-1:0] b,
   input  logic           cin,
   output logic [BPS-1:0] s,
   output logic           cout
);
   if (HOP == carry_cluster_pkg::HOP_SELECT) begin : g_sel
      logic [BPS-1:0] s_lo, s_hi;
      logic           c_lo, c_hi;
      always_comb begin
         c_lo = 1'b0;
         c_hi = 1'b1;
         for (int j = 0; j < BPS; j++) begin
            s_lo[j] = a[j] ^ b[j] ^ c_lo;
            s_hi[j] = a[j] ^ b[j] ^ c_hi;
            c_lo    = (a[j] & b[j]) | (c_lo & (a[j] ^ b[j]));
            c_hi    = (a[j] & b[j]) | (c_hi & (a[j] ^ b[j]));
         end
      end
      assign s    = cin ? s_hi : s_lo;
      assign cout = cin ? c_hi : c_lo;
   end else begin : g_rip
      always_comb begin
         logic c;
         c = cin;
         for (int j = 0; j < BPS; j++) begin
            s[j] = a[j] ^ b[j] ^ c;
            c    = (a[j] & b[j]) | (c & (a[j] ^ b[j]));
         end
         cout = c;
      end
   end
endmodule

// File: rtl/carry_cluster_chain.sv
module carry_cluster_chain #(
   parameter int                          NSLICE = 10,
   parameter int                          BPS    = 2,
   parameter int                          ALT    = 5,
   parameter carry_cluster_pkg::hop_kind_e HOP   = carry_cluster_pkg::HOP_SELECT
) (
   input  logic [NSLICE*BPS-1:0] a,
   input  logic [NSLICE*BPS-1:0] b,
   input  logic                  cin,
   input  logic                  upper,
   output logic [NSLICE*BPS-1:0] s,
   output logic                  cout
);
   localparam int W     = NSLICE * BPS;
   localparam int LOW_W = ALT * BPS;

   logic [NSLICE:0] c;
   logic [W-1:0]    raw;

   for (genvar k = 0; k < NSLICE; k++) begin : g_slice
      logic hop_in;
      if (k == 0) begin : g_first
         assign hop_in = upper ? 1'b0 : cin;
      end else if (k == ALT) begin : g_alt
         // lower half's carry is dropped when the chain begins here
         assign hop_in = upper ? cin : c[k];
      end else begin : g_mid
         assign hop_in = c[k];
      end
      carry_cluster_slice #(.BPS(BPS), .HOP(HOP)) u_slice (
         .a    (a[k*BPS +: BPS]),
         .b    (b[k*BPS +: BPS]),
         .cin  (hop_in),
         .s    (raw[k*BPS +: BPS]),
         .cout (c[k+1])
      );
   end

   assign c[0] = 1'b0;
   assign s    = upper ? {raw[W-1:LOW_W], {LOW_W{1'b0}}} : raw;
   assign cout = c[NSLICE];
endmodule

// File: rtl/carry_cluster.sv
module carry_cluster #(
   parameter int                          NSLICE = 10,
   parameter int                          BPS    = 2,
   parameter int                          LUT_IN = 4,
   parameter int                          ALT    = 5,
   parameter carry_cluster_pkg::hop_kind_e HOP   = carry_cluster_pkg::HOP_SELECT
) (
   input  logic                                   clk,
   input  logic                                   rst,
   input  logic                                   cfg_we,
   input  logic [$clog2(2*NSLICE*BPS)-1:0]        cfg_idx,
   input  logic [(1<<LUT_IN)-1:0]                 cfg_tt,
   input  logic [NSLICE*BPS*LUT_IN-1:0]           din,
   input  logic                                   carry_in,
   input  logic                                   sub,
   input  logic                                   cnt_en,
   input  logic                                   cnt_up,
   input  logic                                   ce,
   input  logic                                   sclr,
   input  logic                                   start_upper,
   output logic [NSLICE*BPS-1:0]                  sum_o,
   output logic [NSLICE*BPS-1:0]                  q_o,
   output logic                                   carry_out
);
   localparam int W  = NSLICE * BPS;
   localparam int AW = $clog2(2 * W);

   if (NSLICE < 2 || BPS < 1 || LUT_IN < 1) begin : g_bad_size
      initial $fatal(1, "carry_cluster: size parameters out of range");
   end
   if (ALT < 1 || ALT >= NSLICE) begin : g_bad_alt
      initial $fatal(1, "carry_cluster: alternate start must be an inner slice");
   end

   logic [W-1:0] lut_a, lut_b;
   logic [W-1:0] add_a, add_b;
   logic         add_ci;

   carry_cluster_lutbank #(.W(W), .LUT_IN(LUT_IN), .AW(AW)) u_luts (
      .clk     (clk),
      .rst     (rst),
      .cfg_we  (cfg_we),
      .cfg_idx (cfg_idx),
      .cfg_tt  (cfg_tt),
      .din     (din),
      .opa     (lut_a),
      .opb     (lut_b)
   );

   // counting reuses the adder: up is q+0+1, down is q+all-ones+0
   always_comb begin
      if (cnt_en) begin
         add_a  = q_o;
         add_b  = cnt_up ? '0 : '1;
         add_ci = cnt_up;
      end else begin
         add_a  = lut_a;
         add_b  = lut_b ^ {W{sub}};
         add_ci = carry_in ^ sub;
      end
   end

   carry_cluster_chain #(.NSLICE(NSLICE), .BPS(BPS), .ALT(ALT), .HOP(HOP)) u_chain (
      .a     (add_a),
      .b     (add_b),
      .cin   (add_ci),
      .upper (start_upper),
      .s     (sum_o),
      .cout  (carry_out)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         q_o <= '0;
      end else if (ce) begin
         if (sclr) q_o <= '0;
         else      q_o <= sum_o;
      end
   end
endmodule

// File: rtl/carry_cluster_chk.sv
module carry_cluster_chk #(
   parameter int W = 20
) (
   input logic         clk,
   input logic         rst,
   input logic         ce,
   input logic         sclr,
   input logic         cnt_en,
   input logic         cnt_up,
   input logic         start_upper,
   input logic [W-1:0] sum_o,
   input logic [W-1:0] q_o,
   input logic         carry_out
);
   a_r5_load: assert property (@(posedge clk) disable iff (rst)
      ce && !sclr |=> q_o == $past(sum_o));

   a_r6_hold: assert property (@(posedge clk) disable iff (rst)
      !ce |=> $stable(q_o));

   a_r7_clear: assert property (@(posedge clk) disable iff (rst)
      ce && sclr |=> q_o == '0);

   a_r8_up: assert property (@(posedge clk) disable iff (rst)
      ce && !sclr && cnt_en && cnt_up && !start_upper |=> q_o == $past(q_o) + W'(1));

   a_r9_down: assert property (@(posedge clk) disable iff (rst)
      ce && !sclr && cnt_en && !cnt_up && !start_upper |=> q_o == $past(q_o) - W'(1));

   a_r9_borrow: assert property (@(posedge clk) disable iff (rst)
      cnt_en && !cnt_up && !start_upper |-> carry_out == (q_o != '0));
endmodule

bind carry_cluster carry_cluster_chk #(.W(W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .ce          (ce),
   .sclr        (sclr),
   .cnt_en      (cnt_en),
   .cnt_up      (cnt_up),
   .start_upper (start_upper),
   .sum_o       (sum_o),
   .q_o         (q_o),
   .carry_out   (carry_out)
);

// File: tb/carry_cluster_bench.sv
module carry_cluster_bench;
   localparam int CLK_P = 10;
   localparam int W     = 20;
   localparam int H     = 10;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cfg_we = 1'b0;
   logic [5:0]    cfg_idx = '0;
   logic [15:0]   cfg_tt = '0;
   logic [79:0]   din = '0;
   logic          carry_in = 1'b0, sub = 1'b0, cnt_en = 1'b0, cnt_up = 1'b0;
   logic          ce = 1'b0, sclr = 1'b0, start_upper = 1'b0;
   logic [W-1:0]  sum_o, q_o;
   logic          carry_out;
   int            total = 0;
   int            bad = 0;

   always #(CLK_P/2) clk = ~clk;

   carry_cluster u_carry_cluster (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_tt(cfg_tt),
      .din(din), .carry_in(carry_in), .sub(sub), .cnt_en(cnt_en), .cnt_up(cnt_up),
      .ce(ce), .sclr(sclr), .start_upper(start_upper),
      .sum_o(sum_o), .q_o(q_o), .carry_out(carry_out)
   );

   // {upper, sub, carry_in, A, B}
   localparam logic [42:0] VEC [12] = '{
      {1'b0, 1'b0, 1'b0, 20'h12345, 20'h0ABCD},
      {1'b0, 1'b0, 1'b0, 20'hFFFFF, 20'h00001},
      {1'b0, 1'b0, 1'b1, 20'h80000, 20'h80000},
      {1'b0, 1'b1, 1'b0, 20'h54321, 20'h12345},
      {1'b0, 1'b1, 1'b0, 20'h00000, 20'h00001},
      {1'b0, 1'b1, 1'b1, 20'h12345, 20'h12345},
      {1'b0, 1'b0, 1'b1, 20'h7FFFF, 20'h00000},
      {1'b1, 1'b0, 1'b0, 20'h003FF, 20'h003FF},
      {1'b1, 1'b0, 1'b0, 20'hFFC00, 20'h00400},
      {1'b1, 1'b1, 1'b0, 20'h40000, 20'h00C00},
      {1'b1, 1'b1, 1'b1, 20'h00000, 20'h00400},
      {1'b1, 1'b0, 1'b1, 20'hA5A5A, 20'h5A5A5}
   };

   function automatic logic [W:0] ref_sum(input logic up, input logic sb, input logic ci,
                                          input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W-1:0] bb;
      logic [H:0]   t;
      bb = sb ? ~b : b;
      if (!up) return {1'b0, a} + {1'b0, bb} + (W+1)'(ci ^ sb);
      t = {1'b0, a[W-1:H]} + {1'b0, bb[W-1:H]} + (H+1)'(ci ^ sb);
      return {t, {H{1'b0}}};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic cfg_write(input int idx, input logic [15:0] tt);
      cfg_we  = 1'b1;
      cfg_idx = 6'(idx);
      cfg_tt  = tt;
      tick();
      cfg_we  = 1'b0;
   endtask

   // nibble bit0 = A bit, bit1 = B bit
   task automatic set_ops(input logic [W-1:0] a, input logic [W-1:0] b);
      for (int i = 0; i < W; i++) din[4*i +: 4] = {2'b00, b[i], a[i]};
   endtask

   task automatic load_q(input logic [W-1:0] v);
      start_upper = 1'b0; sub = 1'b0; carry_in = 1'b0; cnt_en = 1'b0; sclr = 1'b0; ce = 1'b1;
      set_ops(v, '0);
      tick();
      ce = 1'b0;
   endtask

   initial begin
      repeat (3) tick();
      rst = 1'b0;
      chk("R10 q after reset", 32'(q_o), 32'h0);
      set_ops(20'hABCDE, 20'h13579);
      carry_in = 1'b1;
      #1 chk("R10 blank tables give carry_in", 32'({carry_out, sum_o}), 32'h1);
      carry_in = 1'b0;

      for (int i = 0; i < W; i++) begin
         cfg_write(2*i, 16'hAAAA);
         cfg_write(2*i+1, 16'hCCCC);
      end

      foreach (VEC[n]) begin
         logic [W:0] e;
         start_upper = VEC[n][42]; sub = VEC[n][41]; carry_in = VEC[n][40];
         set_ops(VEC[n][39:20], VEC[n][19:0]);
         ce = 1'b1;
         e = ref_sum(VEC[n][42], VEC[n][41], VEC[n][40], VEC[n][39:20], VEC[n][19:0]);
         #1;
         if (VEC[n][42]) chk("R4 upper-start sum", 32'({carry_out, sum_o}), 32'(e));
         else if (VEC[n][41]) chk("R3 subtract", 32'({carry_out, sum_o}), 32'(e));
         else chk("R2 R1 add", 32'({carry_out, sum_o}), 32'(e));
         tick();
         chk("R5 registered sum", 32'(q_o), 32'(e[W-1:0]));
      end
      ce = 1'b0;

      // R4: lower operands must not move the upper result
      start_upper = 1'b1; sub = 1'b0; carry_in = 1'b0;
      set_ops(20'h123FF, 20'h456FF);
      #1 chk("R4 lower half isolated", 32'({carry_out, sum_o}), 32'h05_7400);

      // R6 / R7: clear and count on one edge
      load_q(20'h3C3C3);
      ce = 1'b0; sclr = 1'b1; cnt_en = 1'b1; cnt_up = 1'b1; start_upper = 1'b0;
      tick();
      chk("R6 ce low holds despite sclr and count", 32'(q_o), 32'h3C3C3);
      ce = 1'b1;
      tick();
      chk("R7 sclr beats count", 32'(q_o), 32'h0);
      sclr = 1'b0; ce = 1'b0; cnt_en = 1'b0;

      // R8 up count with wrap
      load_q(20'hFFFFE);
      cnt_en = 1'b1; cnt_up = 1'b1; sub = 1'b1; carry_in = 1'b1; ce = 1'b1;
      #1 chk("R8 no carry below all-ones", 32'(carry_out), 32'h0);
      tick();
      chk("R8 count up", 32'(q_o), 32'hFFFFF);
      #1 chk("R8 carry at all-ones", 32'(carry_out), 32'h1);
      tick();
      chk("R8 wrap to zero", 32'(q_o), 32'h0);

      // R9 down count
      cnt_up = 1'b0;
      #1 chk("R9 no carry at zero", 32'(carry_out), 32'h0);
      tick();
      chk("R9 down wraps", 32'(q_o), 32'hFFFFF);
      #1 chk("R9 carry when nonzero", 32'(carry_out), 32'h1);
      tick();
      chk("R9 count down", 32'(q_o), 32'hFFFFE);

      // R8 / R9 with the chain in the upper half
      sclr = 1'b1; tick(); sclr = 1'b0;
      start_upper = 1'b1; cnt_up = 1'b1;
      tick();
      chk("R8 upper count step", 32'(q_o), 32'h00400);
      cnt_up = 1'b0;
      tick(); tick();
      chk("R9 upper down wrap", 32'(q_o), 32'hFFC00);
      ce = 1'b0; cnt_en = 1'b0; start_upper = 1'b0; sub = 1'b0; carry_in = 1'b0;

      // R1 table numbering: bit 3 second addend forced to constant 1
      cfg_write(7, 16'hFFFF);
      set_ops('0, '0);
      #1 chk("R1 table 7 is bit3 second addend", 32'(sum_o), 32'h8);
      cfg_write(7, 16'hCCCC);
      for (int i = 0; i < W; i++) cfg_write(2*i, 16'h5555);
      set_ops(20'h0F0F0, 20'h00011);
      #1 chk("R1 inverting first addend", 32'({carry_out, sum_o}), 32'(ref_sum(1'b0, 1'b0, 1'b0, ~20'h0F0F0, 20'h00011)));

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule